// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block steps through the elements of one vector operation. When a new operation is issued, it takes the vector length, the scalar or vector kind of each operand, a map-reduce enable and a reverse enable. It then presents one element index per accepted cycle. For every operand it also presents the register index to use on that step. A scalar operand keeps its base register. A vector operand adds the element index to its base.

A scalar destination normally means the operation produces a single result, so the loop ends after its first step. Setting map-reduce removes that early stop. The loop then runs over every element while the scalar destination keeps being read and written, and this is how reductions are formed. A vector destination that reads the previous element's result forms a running prefix sum. In reverse mode the element index counts down from the length minus one to zero. Decode, register-file access and execution are handled outside the block.

Top module: `vec_loop_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `elem_idx` is 0.
- R2: In forward mode with a vector destination, the accepted steps carry element indices 0, 1, ..., VL-1 in that order. One step is consumed on every cycle in which `busy` and `rdy` are both high.
- R3: While `busy` is high and `rdy` is low, `busy`, `elem_idx` and `reg_idx` keep their values.
- R4: With `reverse` set, the accepted steps carry element indices VL-1, VL-2, ..., 0.
- R5: When the destination is scalar (`op_scalar` bit 0 = 1) and `map_reduce` is 0, exactly one step is issued. That step is element 0, or element VL-1 in reverse mode.
- R6: When the destination is scalar and `map_reduce` is 1, all VL steps are issued.
- R7: A start with VL = 0 issues no step. `busy` stays 0 and `done` is 1 in the cycle after the start.
- R8: On each step, operand k's register index (bits k*REG_W upward of `reg_idx`) equals its base when `op_scalar[k]` is 1. Otherwise it equals base + `elem_idx` modulo 2^REG_W. Operand 0 is the destination.
- R9: `done` is high for exactly one cycle, in the cycle after the final accepted step, and `busy` is 0 then.
- R10: A `start` raised while `busy` is high is ignored. The running sequence and its register indices continue unchanged.
- R11: With a vector destination, `map_reduce` has no effect on the step sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue a new operation; accepted only while idle |
| vl | input | VL_W | Vector length of the operation |
| op_scalar | input | NOPS | Per-operand scalar flag; bit 0 is the destination |
| map_reduce | input | 1 | Disables the scalar-destination early stop |
| reverse | input | 1 | Iterate from VL-1 down to 0 |
| base | input | NOPS*REG_W | Base register index of each operand |
| rdy | input | 1 | Downstream accepts the current step |
| busy | output | 1 | A step is being presented |
| elem_idx | output | VL_W | Element index of the current step |
| reg_idx | output | NOPS*REG_W | Register index of each operand for the current step |
| done | output | 1 | One-cycle pulse after the loop finishes |

## Verification
The start edge loads the first step. `busy`, `elem_idx` and `reg_idx` are therefore valid in the cycle after `start`, and each following step appears one cycle after the edge that accepted the previous one. `done` is registered and rises one cycle after the final accepted step, or one cycle after a start with zero length. The bench drives its inputs on the falling edge and reads the outputs on the next falling edge. Before reading, it advances its own model of the step position only for cycles in which it had driven `rdy` high. This keeps every comparison aligned to the exact cycle in which a result is due.

// File: rtl/vec_loop_seq.sv
module vec_loop_seq #(
  parameter int VL_W  = 7,
  parameter int REG_W = 7,
  parameter int NOPS  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [VL_W-1:0]       vl,
  input  logic [NOPS-1:0]       op_scalar,
  input  logic                  map_reduce,
  input  logic                  reverse,
  input  logic [NOPS*REG_W-1:0] base,
  input  logic                  rdy,
  output logic                  busy,
  output logic [VL_W-1:0]       elem_idx,
  output logic [NOPS*REG_W-1:0] reg_idx,
  output logic                  done
);
  localparam logic [VL_W-1:0] ONE = VL_W'(1);

  logic                  busy_q, done_q, rev_q;
  logic [VL_W-1:0]       idx_q, left_q;
  logic [NOPS-1:0]       sca_q;
  logic [NOPS*REG_W-1:0] base_q;
  logic                  last;

  assign last     = (left_q == ONE);
  assign busy     = busy_q;
  assign done     = done_q;
  assign elem_idx = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rev_q  <= 1'b0;
      idx_q  <= '0;
      left_q <= '0;
      sca_q  <= '0;
      base_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          rev_q  <= reverse;
          sca_q  <= op_scalar;
          base_q <= base;
          if (vl == '0) begin
            done_q <= 1'b1;
          end else begin
            busy_q <= 1'b1;
            idx_q  <= reverse ? vl - ONE : '0;
            left_q <= (op_scalar[0] && !map_reduce) ? ONE : vl;
          end
        end
      end else if (rdy) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q  <= rev_q ? idx_q - ONE : idx_q + ONE;
          left_q <= left_q - ONE;
        end
      end
    end
  end

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    logic [REG_W-1:0] b;
    assign b = base_q[k*REG_W +: REG_W];
    assign reg_idx[k*REG_W +: REG_W] = sca_q[k] ? b : b + REG_W'(idx_q);

    p_scalar_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && $past(busy_q) && sca_q[k] |-> reg_idx[k*REG_W +: REG_W] == $past(reg_idx[k*REG_W +: REG_W]));
  end

  p_fwd_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && rdy && !last && !rev_q |=> elem_idx == $past(elem_idx) + ONE);
  p_rev_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && rdy && !last && rev_q |=> elem_idx == $past(elem_idx) - ONE);
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !rdy |=> busy_q && $stable(elem_idx) && $stable(reg_idx));
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  p_finish_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && rdy && last |=> done_q && !busy_q);
  p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && start && vl == '0 |=> done_q && !busy_q);
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start && !rdy |=> $stable(reg_idx) && $stable(elem_idx));
endmodule

// File: tb/vec_loop_seq_tb.sv
module vec_loop_seq_tb;
  localparam int VL_W = 7, REG_W = 7, NOPS = 3;

  logic clk = 0, rst_n = 0, start = 0, map_reduce = 0, reverse = 0, rdy = 0;
  logic [VL_W-1:0] vl = '0;
  logic [NOPS-1:0] op_scalar = '0;
  logic [NOPS*REG_W-1:0] base = '0;
  logic busy, done;
  logic [VL_W-1:0] elem_idx;
  logic [NOPS*REG_W-1:0] reg_idx;

  int checks = 0, fails = 0, cycles = 0;

  vec_loop_seq #(.VL_W(VL_W), .REG_W(REG_W), .NOPS(NOPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .op_scalar(op_scalar),
    .map_reduce(map_reduce), .reverse(reverse), .base(base), .rdy(rdy),
    .busy(busy), .elem_idx(elem_idx), .reg_idx(reg_idx), .done(done));

  always #5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_steps(int l, bit sd, bit mr);
    if (l == 0) return 0;
    if (sd && !mr) return 1;
    return l;
  endfunction

  function automatic int exp_idx(int l, bit rv, int i);
    return rv ? l - 1 - i : i;
  endfunction

  function automatic int exp_reg(bit sc, int b, int idx);
    return sc ? b : (b + idx) % (1 << REG_W);
  endfunction

  task automatic run(int l, bit [NOPS-1:0] sc, bit mr, bit rv, int rdy_pct, bit junk, string tag);
    bit [NOPS*REG_W-1:0] bb;
    int n, i;
    bit stalled;
    bb = NOPS*REG_W'($urandom);
    @(negedge clk);
    start = 1; vl = VL_W'(l); op_scalar = sc; map_reduce = mr; reverse = rv; base = bb; rdy = 0;
    @(negedge clk);
    start = 0;
    n = exp_steps(l, sc[0], mr);
    i = 0;
    stalled = 0;
    while (i < n) begin
      chk(stalled ? "R3 busy" : {tag, " busy"}, int'(busy), 1);
      chk(stalled ? "R3 idx" : {tag, " idx"}, int'(elem_idx), exp_idx(l, rv, i));
      for (int k = 0; k < NOPS; k++)
        chk(junk ? "R10 reg" : "R8 reg", int'(reg_idx[k*REG_W +: REG_W]),
            exp_reg(sc[k], int'(bb[k*REG_W +: REG_W]), exp_idx(l, rv, i)));
      rdy = (($urandom % 100) < rdy_pct);
      if (junk) begin
        start = $urandom_range(0, 1);
        vl = VL_W'($urandom); base = NOPS*REG_W'($urandom);
        reverse = ~rv; op_scalar = ~sc;
      end
      @(negedge clk);
      start = 0;
      stalled = !rdy;
      if (rdy) i++;
    end
    rdy = 0;
    chk("R9 busy low at end", int'(busy), 0);
    chk(l == 0 ? "R7 done" : "R9 done", int'(done), 1);
    @(negedge clk);
    chk("R9 done pulse", int'(done), 0);
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected 0", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 idx", int'(elem_idx), 0);
    rst_n = 1;

    run(8, 3'b000, 0, 0, 100, 0, "R2");
    run(8, 3'b000, 0, 1, 100, 0, "R4");
    run(6, 3'b010, 0, 0, 50, 0, "R3");
    run(5, 3'b001, 0, 0, 100, 0, "R5");
    run(5, 3'b001, 0, 1, 100, 0, "R5");
    run(7, 3'b001, 1, 0, 70, 0, "R6");
    run(7, 3'b101, 1, 1, 70, 0, "R6");
    run(0, 3'b000, 0, 0, 100, 0, "R7");
    run(0, 3'b001, 1, 1, 100, 0, "R7");
    run(9, 3'b000, 1, 0, 100, 0, "R11");
    run(9, 3'b110, 1, 1, 60, 0, "R11");
    run(10, 3'b100, 0, 0, 40, 1, "R10");
    run(1, 3'b000, 0, 1, 100, 0, "R4");
    run(127, 3'b000, 0, 0, 100, 0, "R2");
    for (int t = 0; t < 60; t++)
      run($urandom_range(0, 20), 3'($urandom), 1'($urandom), 1'($urandom),
          $urandom_range(30, 100), 1'($urandom), "R2");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule